// File: doc/BRIEF.md
# Torus-Linked Array Compute Cell

This block is one 32-bit compute cell meant to be tiled into a two-dimensional array whose edges wrap around, so every cell has exactly four neighbours. When a sequencer pulses `start`, the cell decodes the instruction word and picks two operands. Each operand can be one of its four local registers, its own output register, the output register of the north, south, east or west neighbour, a sign-extended immediate, or a load result supplied from outside. It then computes a result. Simple ALU operations finish at once. A multiply runs through a three-stage pipeline while `busy` is high.

The cell raises `done` for one cycle when its result is ready. It then keeps the result pending and its visible output register unchanged until the array-wide `commit` strobe arrives. This lets the sequencer stretch an array instruction until the slowest cell has finished. Because the output register only moves on `commit`, neighbours see a new value only from the next array instruction on. A branch-if-zero operation raises a branch request with a target index taken from the immediate field.

The controller has three named states. In IDLE the cell waits for `start`. IDLE goes to MULT on a multiply start and to HOLD on any other start. In MULT the multiplier is in flight, and MULT goes to HOLD when the product emerges. In HOLD the result is pending, and HOLD goes back to IDLE on `commit`.

Top module: `tpe_cell`

## Requirements
- R1: After reset the output register and R0 to R3 read zero, and `done`, `busy` and `br_req` are low.
- R2: The instruction word is {imm[15:0] at bits 30:15, wout at bit 14, dst at bits 13:12, selB at bits 11:8, selA at bits 7:4, opcode at bits 3:0}. The selector codes are 0-3 for R0-R3, 4 for the cell's own output register, 5 for north, 6 for south, 7 for east, 8 for west, 9 for the sign-extended immediate and 10 for `ld_data`. Codes 11-15 give zero.
- R3: Opcode 1 adds A+B, 2 subtracts A-B, 3 is AND, 4 is OR, 5 is XOR and 11 moves A. All results wrap modulo 2^32.
- R4: Opcode 6 shifts A left, 7 shifts A right logically and 8 shifts A right arithmetically. The shift distance is B[4:0] in every case.
- R5: For every opcode except 9, `done` is high for exactly the one cycle after the start edge, and `busy` stays low.
- R6: Opcode 9 produces the low 32 bits of A*B. `busy` is high for the two cycles after the start edge, then `done` is high for one cycle with `busy` low.
- R7: The result is written only at a `commit` edge in HOLD. With wout=1 it goes to the output register, and with wout=0 it goes to R[dst] while the output register stays unchanged. Opcodes 0, 10 and 12-15 write nothing.
- R8: Opcode 10 raises `br_req` from the cycle after start until commit, with `br_tgt` equal to imm[7:0], only when operand A is zero.
- R9: `start` is ignored outside IDLE, and `commit` is ignored outside HOLD. This includes a `commit` during a multiply.
- R10: The output register does not change in any cycle without a `commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing `instr` (honoured in IDLE) |
| instr | input | 31 | Instruction word |
| nb_north | input | 32 | North neighbour output register |
| nb_south | input | 32 | South neighbour output register |
| nb_east | input | 32 | East neighbour output register |
| nb_west | input | 32 | West neighbour output register |
| ld_data | input | 32 | Load result operand |
| commit | input | 1 | Array-wide end-of-instruction strobe |
| out_q | output | 32 | Output register, visible to neighbours |
| busy | output | 1 | Multi-cycle operation in flight |
| done | output | 1 | One-cycle completion pulse |
| br_req | output | 1 | Branch request |
| br_tgt | output | 8 | Branch target instruction index |

## Verification
The bench sweeps every opcode that writes a result against all sixteen codes for each of the two selectors. It also keeps neighbour, load and register values distinct, so a design with a swapped mux leg, a missing sign extension or an unassigned code that leaks a value produces a wrong result word. Shift operands carry high bits above bit 4, so a cell that used the whole B word as the distance, or did a logical shift where an arithmetic one was due, gives a different output. The bench pulses `commit` during a multiply and holds `start` high in HOLD; a cell that honoured either would retire early or be overwritten. It also checks the multiply's busy window cycle by cycle, which catches a pipeline that is one stage short or long, and it checks branch-if-zero with both zero and non-zero operands.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
    localparam int OP_W  = 4;
    localparam int SEL_W = 4;
    localparam int DST_W = 2;
    localparam int NREG  = 1 << DST_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_AND = 4'd3,
        OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_SLL = 4'd6,  OP_SRL = 4'd7,
        OP_SRA = 4'd8,  OP_MUL = 4'd9,  OP_BZ  = 4'd10, OP_MOV = 4'd11
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_R0 = 4'd0, SRC_R1 = 4'd1, SRC_R2 = 4'd2, SRC_R3 = 4'd3,
        SRC_OUT = 4'd4, SRC_N = 4'd5, SRC_S = 4'd6, SRC_E = 4'd7,
        SRC_W = 4'd8, SRC_IMM = 4'd9, SRC_LD = 4'd10
    } src_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MULT = 2'd1,
        S_HOLD = 2'd2
    } state_e;

    function automatic logic op_writes(input logic [OP_W-1:0] op);
        return (op >= 4'd1 && op <= 4'd9) || (op == 4'd11);
    endfunction
endpackage

// File: rtl/tpe_opsel.sv
module tpe_opsel
    import tpe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [SEL_W-1:0]         sel,
    input  logic [NREG-1:0][DW-1:0]  regs,
    input  logic [DW-1:0]            own_out,
    input  logic [DW-1:0]            nb_n,
    input  logic [DW-1:0]            nb_s,
    input  logic [DW-1:0]            nb_e,
    input  logic [DW-1:0]            nb_w,
    input  logic [DW-1:0]            imm_ext,
    input  logic [DW-1:0]            ld,
    output logic [DW-1:0]            val
);
    always_comb begin
        case (sel)
            SRC_R0:  val = regs[0];
            SRC_R1:  val = regs[1];
            SRC_R2:  val = regs[2];
            SRC_R3:  val = regs[3];
            SRC_OUT: val = own_out;
            SRC_N:   val = nb_n;
            SRC_S:   val = nb_s;
            SRC_E:   val = nb_e;
            SRC_W:   val = nb_w;
            SRC_IMM: val = imm_ext;
            SRC_LD:  val = ld;
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/tpe_alu.sv
module tpe_alu
    import tpe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    localparam int SHW = $clog2(DW);
    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << sh;
            OP_SRL:  y = a >> sh;
            OP_SRA:  y = $unsigned($signed(a) >>> sh);
            OP_MOV:  y = a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tpe_mul.sv
module tpe_mul #(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          out_vld,
    output logic [DW-1:0] y
);
    localparam int XTRA = LAT - 2;

    logic [DW-1:0] a_q, b_q, p_q;
    logic          v1_q, v2_q;
    logic [DW-1:0] pd [0:XTRA];
    logic          vd [0:XTRA];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; p_q <= '0;
            v1_q <= 1'b0; v2_q <= 1'b0;
        end else begin
            v1_q <= in_vld;
            if (in_vld) begin
                a_q <= a;
                b_q <= b;
            end
            v2_q <= v1_q;
            if (v1_q) p_q <= a_q * b_q;
        end
    end

    assign pd[0] = p_q;
    assign vd[0] = v2_q;

    for (genvar i = 1; i <= XTRA; i++) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pd[i] <= '0;
                vd[i] <= 1'b0;
            end else begin
                pd[i] <= pd[i-1];
                vd[i] <= vd[i-1];
            end
        end
    end

    assign y       = pd[XTRA];
    assign out_vld = vd[XTRA];

    AST_MUL_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld); // R6
endmodule

// File: rtl/tpe_cell.sv
module tpe_cell
    import tpe_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IMM_W   = 16,
    parameter int TGT_W   = 8,
    parameter int MUL_LAT = 3,
    localparam int INSTR_W = OP_W + 2 * SEL_W + DST_W + 1 + IMM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DW-1:0]      nb_north,
    input  logic [DW-1:0]      nb_south,
    input  logic [DW-1:0]      nb_east,
    input  logic [DW-1:0]      nb_west,
    input  logic [DW-1:0]      ld_data,
    input  logic               commit,
    output logic [DW-1:0]      out_q,
    output logic               busy,
    output logic               done,
    output logic               br_req,
    output logic [TGT_W-1:0]   br_tgt
);
    localparam int A_LO   = OP_W;
    localparam int B_LO   = A_LO + SEL_W;
    localparam int D_LO   = B_LO + SEL_W;
    localparam int WO_BIT = D_LO + DST_W;
    localparam int IM_LO  = WO_BIT + 1;

    logic [OP_W-1:0]  f_op;
    logic [SEL_W-1:0] f_sa, f_sb;
    logic [DST_W-1:0] f_dst;
    logic             f_wout;
    logic [IMM_W-1:0] f_imm;
    logic [DW-1:0]    imm_ext;

    assign f_op    = instr[A_LO-1:0];
    assign f_sa    = instr[B_LO-1:A_LO];
    assign f_sb    = instr[D_LO-1:B_LO];
    assign f_dst   = instr[WO_BIT-1:D_LO];
    assign f_wout  = instr[WO_BIT];
    assign f_imm   = instr[INSTR_W-1:IM_LO];
    assign imm_ext = {{(DW-IMM_W){f_imm[IMM_W-1]}}, f_imm};

    state_e                  state_q, state_d;
    logic [NREG-1:0][DW-1:0] rf_q;
    logic [DW-1:0]           out_r, res_q;
    logic [OP_W-1:0]         op_q;
    logic [DST_W-1:0]        dst_q;
    logic                    wout_q, br_q, fresh_q;
    logic [TGT_W-1:0]        tgt_q;

    logic [DW-1:0] opa, opb, alu_y, mul_y;
    logic          mul_vld, take, mul_go;

    tpe_opsel #(.DW(DW)) u_sel_a (
        .sel(f_sa), .regs(rf_q), .own_out(out_r),
        .nb_n(nb_north), .nb_s(nb_south), .nb_e(nb_east), .nb_w(nb_west),
        .imm_ext(imm_ext), .ld(ld_data), .val(opa)
    );

    tpe_opsel #(.DW(DW)) u_sel_b (
        .sel(f_sb), .regs(rf_q), .own_out(out_r),
        .nb_n(nb_north), .nb_s(nb_south), .nb_e(nb_east), .nb_w(nb_west),
        .imm_ext(imm_ext), .ld(ld_data), .val(opb)
    );

    tpe_alu #(.DW(DW)) u_alu (.op(f_op), .a(opa), .b(opb), .y(alu_y));

    assign take   = (state_q == S_IDLE) && start;
    assign mul_go = take && (f_op == OP_MUL);

    tpe_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_vld(mul_go),
        .a(opa), .b(opb), .out_vld(mul_vld), .y(mul_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)   state_d = (f_op == OP_MUL) ? S_MULT : S_HOLD;
            S_MULT: if (mul_vld) state_d = S_HOLD;
            S_HOLD: if (commit)  state_d = S_IDLE;
            default:             state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state_q == S_MULT) && !mul_vld;
        done   = ((state_q == S_MULT) && mul_vld) || ((state_q == S_HOLD) && fresh_q);
        br_req = (state_q == S_HOLD) && br_q;
        br_tgt = tgt_q;
        out_q  = out_r;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0; out_r <= '0; res_q <= '0; op_q <= '0; dst_q <= '0;
            wout_q <= 1'b0; br_q <= 1'b0; fresh_q <= 1'b0; tgt_q <= '0;
        end else begin
            fresh_q <= 1'b0;
            if (take) begin
                op_q    <= f_op;
                dst_q   <= f_dst;
                wout_q  <= f_wout;
                tgt_q   <= f_imm[TGT_W-1:0];
                res_q   <= alu_y;
                br_q    <= (f_op == OP_BZ) && (opa == '0);
                fresh_q <= (f_op != OP_MUL);
            end
            if ((state_q == S_MULT) && mul_vld) res_q <= mul_y;
            if ((state_q == S_HOLD) && commit && op_writes(op_q)) begin
                if (wout_q) out_r        <= res_q;
                else        rf_q[dst_q]  <= res_q;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R6
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R6
    AST_BR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !commit) |=> (br_req && $stable(br_tgt))); // R8
    AST_OUT_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(out_q)); // R10
endmodule

// File: tb/tpe_cell_test.sv
`timescale 1ns/1ps
module tpe_cell_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [30:0] instr = '0;
    logic [31:0] nb_north = 32'h0000_0007, nb_south = 32'h0000_0023;
    logic [31:0] nb_east = 32'hDEAD_BEEF, nb_west = 32'h4000_0001;
    logic [31:0] ld_data = 32'h8000_0005;
    logic        commit = 1'b0;
    logic [31:0] out_q;
    logic        busy, done, br_req;
    logic [7:0]  br_tgt;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rf_m [4];
    logic [31:0] out_m;

    always #2 clk = ~clk;

    tpe_cell uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .nb_north(nb_north), .nb_south(nb_south), .nb_east(nb_east), .nb_west(nb_west),
        .ld_data(ld_data), .commit(commit), .out_q(out_q), .busy(busy),
        .done(done), .br_req(br_req), .br_tgt(br_tgt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [30:0] mk(input int op, sa, sb, dst, wout, input logic [15:0] imm);
        return {imm, wout[0], dst[1:0], sb[3:0], sa[3:0], op[3:0]};
    endfunction

    function automatic logic [31:0] srcv(input int sel, input logic [15:0] imm);
        case (sel)
            0, 1, 2, 3: return rf_m[sel];
            4:  return out_m;
            5:  return nb_north;
            6:  return nb_south;
            7:  return nb_east;
            8:  return nb_west;
            9:  return {{16{imm[15]}}, imm};
            10: return ld_data;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model(input int op, input logic [31:0] a, b);
        case (op)
            1:  return a + b;
            2:  return a - b;
            3:  return a & b;
            4:  return a | b;
            5:  return a ^ b;
            6:  return a << b[4:0];
            7:  return a >> b[4:0];
            8:  return $unsigned($signed(a) >>> b[4:0]);
            9:  return a * b;
            11: return a;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit writes(input int op);
        return (op >= 1 && op <= 9) || op == 11;
    endfunction

    task automatic issue(input int op, sa, sb, dst, wout, input logic [15:0] imm, input string tag);
        logic [31:0] a, b, r;
        bit br;
        a  = srcv(sa, imm);
        b  = srcv(sb, imm);
        r  = model(op, a, b);
        br = (op == 10) && (a == 0);
        start = 1'b1;
        instr = mk(op, sa, sb, dst, wout, imm);
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        if (op == 9) begin
            chk(busy && !done, "R6 busy cycle 1", {30'b0, busy, done}, 32'h2);
            @(negedge clk);
            chk(busy && !done, "R6 busy cycle 2", {30'b0, busy, done}, 32'h2);
            @(negedge clk);
            chk(!busy && done, "R6 done cycle 3", {30'b0, busy, done}, 32'h1);
            @(negedge clk);
            chk(!done, "R6 done one cycle", {31'b0, done}, 32'h0);
        end else begin
            chk(done && !busy, "R5 done after start", {30'b0, busy, done}, 32'h1);
        end
        if (op == 10)
            chk(br_req == br && (!br || br_tgt == imm[7:0]), "R8 branch request",
                {br_req, 23'b0, br_tgt}, {br, 23'b0, imm[7:0]});
        chk(out_q == out_m, "R10 out held before commit", out_q, out_m);
        commit = 1'b1;
        @(posedge clk); @(negedge clk);
        commit = 1'b0;
        if (writes(op)) begin
            if (wout != 0) out_m = r;
            else rf_m[dst] = r;
        end
        chk(out_q == out_m, tag, out_q, out_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) rf_m[i] = 32'h0;
        out_m = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_q == 0 && !busy && !done && !br_req, "R1 reset outputs",
            {out_q[27:0], busy, done, br_req, 1'b0}, 32'h0);
        issue(11, 2, 0, 0, 1, 16'h0, "R1 R2 reset R2 reads zero");

        // R7: load registers with wout=0, out must stay
        issue(11, 9, 0, 1, 0, 16'hFFFF, "R7 write R1 keeps out");
        issue(11, 9, 0, 2, 0, 16'h1234, "R7 write R2 keeps out");
        issue(11, 10, 0, 3, 0, 16'h0, "R7 R10 write R3 from load");
        issue(11, 1, 0, 0, 1, 16'h0, "R7 read back R1");
        issue(11, 3, 0, 0, 1, 16'h0, "R7 read back R3");

        // R9: commit in IDLE ignored
        commit = 1'b1; @(posedge clk); @(negedge clk); commit = 1'b0;
        chk(out_q == out_m && !done, "R9 commit idle ignored", out_q, out_m);

        // near-exhaustive sweep over opcodes and both selectors
        for (int k = 0; k < 10; k++) begin
            int op;
            op = (k == 9) ? 11 : k + 1;
            for (int sa = 0; sa < 16; sa++) begin
                for (int sb = 0; sb < 16; sb++) begin
                    nb_north = 32'h0000_0007 + sa;
                    nb_west  = 32'h4000_0001 ^ (sb << 8);
                    issue(op, sa, sb, 0, 1, 16'h8003 + sb[15:0],
                          (op >= 6 && op <= 8) ? "R2 R4 shift result" :
                          (op == 9) ? "R2 R6 product" : "R2 R3 alu result");
                end
            end
        end

        // R7: non-writing opcodes leave out
        issue(0, 1, 2, 0, 1, 16'h0, "R7 nop writes nothing");
        issue(13, 1, 2, 0, 1, 16'h0, "R7 undefined op writes nothing");

        // R8: branch if zero
        issue(10, 0, 0, 0, 1, 16'h00A5, "R8 taken branch no write");
        issue(10, 1, 0, 0, 1, 16'h003C, "R8 untaken branch no write");
        issue(10, 12, 0, 0, 1, 16'h0077, "R8 R2 unassigned selector zero");

        // R9: start in HOLD ignored
        begin
            logic [31:0] exp;
            exp = rf_m[1] + rf_m[2];
            start = 1'b1; instr = mk(1, 1, 2, 0, 1, 16'h0);
            @(posedge clk); @(negedge clk);
            chk(done, "R5 done before second start", {31'b0, done}, 32'h1);
            instr = mk(11, 9, 0, 0, 1, 16'h0055);
            @(posedge clk); @(negedge clk);
            start = 1'b0; commit = 1'b1;
            @(posedge clk); @(negedge clk);
            commit = 1'b0; out_m = exp;
            chk(out_q == exp, "R9 start in hold ignored", out_q, exp);
        end

        // R9: commit during multiply ignored
        begin
            logic [31:0] exp, old;
            exp = rf_m[1] * rf_m[3];
            old = out_m;
            start = 1'b1; instr = mk(9, 1, 3, 0, 1, 16'h0);
            @(posedge clk); @(negedge clk);
            start = 1'b0; commit = 1'b1;
            @(posedge clk); @(negedge clk);
            commit = 1'b0;
            chk(out_q == old && busy, "R9 commit in mult ignored", out_q, old);
            @(negedge clk);
            chk(done, "R6 done after ignored commit", {31'b0, done}, 32'h1);
            @(negedge clk);
            commit = 1'b1;
            @(posedge clk); @(negedge clk);
            commit = 1'b0; out_m = exp;
            chk(out_q == exp, "R9 R6 product after late commit", out_q, exp);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule